// File: doc/BRIEF.md
# FEC Symbol-Error Threshold Capture Unit

This block sits behind a receiver that has already turned its line signal into a parallel word of hard bit decisions. It checks that word against a self-aligning PRBS31 reference, folds the mismatching bits into fixed-size forward-error-correction codewords built from multi-bit symbols, and counts per codeword how many symbols hold at least one wrong bit. Scattered errors that a Reed-Solomon decoder would fix are only counted. A codeword whose symbol-error count rises above a programmable threshold, or that has too many symbol errors to be correctable, is recorded in a small event store for later analysis.

Each received word holds a whole number of symbols. Symbols carry two bits per line symbol, so their width is even. A sync input marks the first word of a codeword and restarts the codeword index. Otherwise the framing runs freely. Four saturating totals (bit errors, symbol errors, threshold events, uncorrectable codewords) and a per-codeword result report the link quality. A registered read port returns the stored events.

Top module: `fec_sym_capture`

## Requirements
- R1: Received bits are compared, bit DW-1 first in time, with the PRBS31 sequence b[n] = b[n-31] XOR b[n-28]; while locked, every mismatching bit adds one to `bit_err_total`.
- R2: Out of lock, the checker loads received bits as its state. The first 31 bits only seed it. Each later bit is compared with its prediction. Lock is declared at the end of the word in which 64 consecutive predictions have matched. Mismatches out of lock are not counted anywhere.
- R3: A word that has more than DW/2 bit errors while locked drops lock after its errors have been counted, and the checker re-seeds from fresh received bits.
- R4: Symbol j of a word is bits [SYM_BITS*j+SYM_BITS-1 : SYM_BITS*j]. A symbol is in error when any of its bits mismatched, and each such symbol adds one to `sym_err_total`.
- R5: A codeword is CW_SYMS/(DW/SYM_BITS) valid words. A word with `in_sync` high is word 0 of a codeword with index 0, and the index then rises by one per codeword.
- R6: A codeword is a threshold event when its symbol-error count is strictly greater than `thresh`; a count equal to it is ignored. Each event adds one to `event_total`.
- R7: A codeword with more than UNC_LIMIT symbol errors raises `cw_uncorr` and adds one to `uncorr_total`.
- R8: A codeword that is an event, uncorrectable, or both, is stored exactly once in the next free slot (slots fill from 0). The entry holds its index, its symbol-error count, the uncorrectable bit, and its first CAP_WORDS received words.
- R9: Once CAP_DEPTH entries are stored, no further entry is written and `cap_count` stays at CAP_DEPTH, while all totals keep counting.
- R10: Each total saturates at 2^CNT_W-1 instead of wrapping.
- R11: A one-cycle `clr` sets all four totals and `cap_count` to zero.
- R12: The read port returns the word selected by `rd_slot`/`rd_word` and that slot's metadata one clock after the address is presented.
- R13: After reset all totals and `cap_count` are zero and `locked` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of totals and event store fill |
| in_vld | input | 1 | Received word valid |
| in_sync | input | 1 | Marks the word as first of codeword 0 |
| in_data | input | DW | Received bits, MSB first in time |
| thresh | input | SC_W | Symbol-error threshold per codeword |
| locked | output | 1 | PRBS checker is aligned |
| cw_done | output | 1 | Pulse: a codeword has completed |
| cw_idx | output | CWI_W | Index of the completed codeword |
| cw_syms | output | SC_W | Symbol errors in the completed codeword |
| cw_event | output | 1 | Completed codeword exceeded the threshold |
| cw_uncorr | output | 1 | Completed codeword is uncorrectable |
| bit_err_total | output | CNT_W | Saturating bit-error total |
| sym_err_total | output | CNT_W | Saturating symbol-error total |
| event_total | output | CNT_W | Saturating threshold-event total |
| uncorr_total | output | CNT_W | Saturating uncorrectable total |
| cap_count | output | CC_W | Number of stored entries |
| rd_slot | input | SLOT_W | Entry to read |
| rd_word | input | WRD_W | Stored word within the entry |
| rd_data | output | DW | Stored received word |
| rd_cw_idx | output | CWI_W | Stored codeword index |
| rd_syms | output | SC_W | Stored symbol-error count |
| rd_uncorr | output | 1 | Stored uncorrectable bit |

## Verification
The assertions assume that `in_sync` arrives only with a valid word, and that `thresh` is read in the same cycle as the last word of each codeword. The lock-hold property also assumes that a word with no more than half its bits wrong never costs lock. The bench changes `thresh` only while the input is idle, raises sync only together with a valid word, and limits injected errors to at most eight bits of a twenty-bit word. The one exception is the deliberate fully inverted word that exercises loss of lock. It sweeps every symbol-error count from zero to a full codeword against two thresholds, so the equal-to-threshold, correctable-limit and full-store boundaries are all crossed.

// File: rtl/fec_cap_pkg.sv
package fec_cap_pkg;
  typedef enum logic {HUNT = 1'b0, LOCK = 1'b1} lock_e;
  localparam int PRBS_LEN = 31;
  localparam int PRBS_TAP = 28;
  localparam int NUM_TOT  = 4;
endpackage

// File: rtl/fec_prbs_chk.sv
module fec_prbs_chk
  import fec_cap_pkg::*;
#(
  parameter int W         = 40,
  parameter int LOCK_RUN  = 64,
  parameter int LOSS_ERRS = W / 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld,
  input  logic [W-1:0] data,
  output logic [W-1:0] err,
  output logic         locked
);
  localparam int ERRC_W = $clog2(W + 1);
  localparam int FILL_W = $clog2(PRBS_LEN + 1);
  localparam int RUN_W  = $clog2(LOCK_RUN + 1);

  lock_e                state;
  logic [PRBS_LEN-1:0]  st_q, st_n;
  logic [FILL_W-1:0]    fill_q, fill_n;
  logic [RUN_W-1:0]     run_q, run_n;
  logic [ERRC_W-1:0]    n_err;
  logic                 pred;

  // Walk the word bit by bit, oldest bit first.
  always_comb begin
    st_n   = st_q;
    fill_n = fill_q;
    run_n  = run_q;
    err    = '0;
    pred   = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      pred = st_n[PRBS_LEN-1] ^ st_n[PRBS_TAP-1];
      if (state == LOCK) begin
        err[i] = data[i] ^ pred;
        st_n   = {st_n[PRBS_LEN-2:0], pred};
      end else begin
        if (fill_n == FILL_W'(PRBS_LEN)) begin
          if (data[i] == pred) begin
            if (run_n < RUN_W'(LOCK_RUN)) run_n = run_n + 1'b1;
          end else begin
            run_n = '0;
          end
        end else begin
          fill_n = fill_n + 1'b1;
        end
        st_n = {st_n[PRBS_LEN-2:0], data[i]};
      end
    end
  end

  always_comb begin
    n_err = '0;
    for (int i = 0; i < W; i++) n_err = n_err + ERRC_W'(err[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= HUNT;
      st_q   <= '0;
      fill_q <= '0;
      run_q  <= '0;
    end else if (vld) begin
      st_q <= st_n;
      if (state == HUNT) begin
        fill_q <= fill_n;
        run_q  <= run_n;
        if (run_n == RUN_W'(LOCK_RUN)) state <= LOCK;
      end else if (n_err > ERRC_W'(LOSS_ERRS)) begin
        state  <= HUNT;
        fill_q <= '0;
        run_q  <= '0;
      end
    end
  end

  assign locked = (state == LOCK);

  // R3: a locked word with few errors keeps lock
  a_r3_hold_lock: assert property (@(posedge clk) disable iff (rst)
    (locked && vld && n_err <= ERRC_W'(LOSS_ERRS)) |=> locked);
  // R2: lock is only gained on a received word
  a_r2_lock_on_word: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(vld));
endmodule

// File: rtl/fec_cw_frame.sv
module fec_cw_frame #(
  parameter int W         = 40,
  parameter int SYM       = 10,
  parameter int CW_SYMS   = 544,
  parameter int UNC_LIMIT = 16,
  parameter int CWI_W     = 16,
  localparam int SPB      = W / SYM,
  localparam int BEATS    = CW_SYMS / SPB,
  localparam int BEAT_W   = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int SC_W     = $clog2(CW_SYMS + 1),
  localparam int BIT_W    = $clog2(W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld,
  input  logic              sync,
  input  logic [W-1:0]      data,
  input  logic [W-1:0]      err,
  input  logic [SC_W-1:0]   thresh,
  output logic              st_vld,
  output logic [W-1:0]      st_data,
  output logic [BEAT_W-1:0] st_word,
  output logic [BIT_W-1:0]  st_bits,
  output logic [BIT_W-1:0]  st_syms,
  output logic              st_evt,
  output logic              st_unc,
  output logic              commit,
  output logic [CWI_W-1:0]  c_idx,
  output logic [SC_W-1:0]   c_syms,
  output logic              cw_done,
  output logic [CWI_W-1:0]  cw_idx,
  output logic [SC_W-1:0]   cw_syms,
  output logic              cw_event,
  output logic              cw_uncorr
);
  logic [BEAT_W-1:0] cnt_q, b0;
  logic [CWI_W-1:0]  cwi_q, i0;
  logic              last0;
  logic              s1_vld;
  logic [W-1:0]      s1_data, s1_err;
  logic [BEAT_W-1:0] s1_beat;
  logic [CWI_W-1:0]  s1_cwi;
  logic [SPB-1:0]    sym_hit;
  logic [BIT_W-1:0]  n_sym, n_bit;
  logic [SC_W-1:0]   acc_q, tot;
  logic              last1, ev, un;

  // Stage 0: word position and codeword index.
  assign b0    = sync ? '0 : cnt_q;
  assign i0    = sync ? '0 : cwi_q;
  assign last0 = (b0 == BEAT_W'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      cwi_q  <= '0;
      s1_vld <= 1'b0;
    end else begin
      s1_vld <= vld;
      if (vld) begin
        cnt_q <= last0 ? '0 : b0 + 1'b1;
        cwi_q <= last0 ? i0 + 1'b1 : i0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (vld) begin
      s1_data <= data;
      s1_err  <= err;
      s1_beat <= b0;
      s1_cwi  <= i0;
    end
  end

  // Stage 1: symbol error flags and counts.
  for (genvar j = 0; j < SPB; j++) begin : g_sym
    assign sym_hit[j] = |s1_err[j*SYM +: SYM];
  end

  always_comb begin
    n_sym = '0;
    n_bit = '0;
    for (int j = 0; j < SPB; j++) n_sym = n_sym + BIT_W'(sym_hit[j]);
    for (int i = 0; i < W; i++)   n_bit = n_bit + BIT_W'(s1_err[i]);
  end

  assign last1 = (s1_beat == BEAT_W'(BEATS - 1));
  assign tot   = ((s1_beat == '0) ? '0 : acc_q) + SC_W'(n_sym);
  assign ev    = (tot > thresh);
  assign un    = (tot > SC_W'(UNC_LIMIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      cw_done   <= 1'b0;
      cw_idx    <= '0;
      cw_syms   <= '0;
      cw_event  <= 1'b0;
      cw_uncorr <= 1'b0;
    end else begin
      cw_done <= s1_vld && last1;
      if (s1_vld) acc_q <= tot;
      if (s1_vld && last1) begin
        cw_idx    <= s1_cwi;
        cw_syms   <= tot;
        cw_event  <= ev;
        cw_uncorr <= un;
      end
    end
  end

  assign st_vld  = s1_vld;
  assign st_data = s1_data;
  assign st_word = s1_beat;
  assign st_bits = s1_vld ? n_bit : '0;
  assign st_syms = s1_vld ? n_sym : '0;
  assign st_evt  = s1_vld && last1 && ev;
  assign st_unc  = s1_vld && last1 && un;
  assign commit  = s1_vld && last1 && (ev || un);
  assign c_idx   = s1_cwi;
  assign c_syms  = tot;

  // R5: a codeword never reports more errored symbols than it has
  a_r5_sym_bound: assert property (@(posedge clk) disable iff (rst)
    cw_done |-> (cw_syms <= SC_W'(CW_SYMS)));
  // R6: the event flag follows the threshold seen with the last word
  a_r6_evt_vs_thresh: assert property (@(posedge clk) disable iff (rst)
    cw_done |-> (cw_event == (cw_syms > $past(thresh))));
  // R7: uncorrectable only above the correctable limit
  a_r7_unc_limit: assert property (@(posedge clk) disable iff (rst)
    (cw_done && cw_uncorr) |-> (cw_syms > SC_W'(UNC_LIMIT)));
endmodule

// File: rtl/fec_cap_store.sv
module fec_cap_store #(
  parameter int W      = 40,
  parameter int DEPTH  = 128,
  parameter int CAPW   = 4,
  parameter int BEAT_W = 8,
  parameter int CWI_W  = 16,
  parameter int SC_W   = 10,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int WRD_W  = (CAPW > 1) ? $clog2(CAPW) : 1,
  localparam int CC_W   = $clog2(DEPTH + 1),
  localparam int ADDR_W = (DEPTH * CAPW > 1) ? $clog2(DEPTH * CAPW) : 1,
  localparam int M_W    = 1 + SC_W + CWI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_vld,
  input  logic [BEAT_W-1:0] wr_word,
  input  logic [W-1:0]      wr_data,
  input  logic              commit,
  input  logic [CWI_W-1:0]  c_idx,
  input  logic [SC_W-1:0]   c_syms,
  input  logic              c_unc,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [WRD_W-1:0]  rd_word,
  output logic [CC_W-1:0]   cap_count,
  output logic [W-1:0]      rd_data,
  output logic [CWI_W-1:0]  rd_idx,
  output logic [SC_W-1:0]   rd_syms,
  output logic              rd_unc
);
  logic [W-1:0]      dmem [DEPTH*CAPW];
  logic [M_W-1:0]    mmem [DEPTH];
  logic [M_W-1:0]    rmeta;
  logic              room;
  logic [SLOT_W-1:0] slot;
  logic [ADDR_W-1:0] waddr, raddr;

  assign room  = (cap_count < CC_W'(DEPTH));
  assign slot  = cap_count[SLOT_W-1:0];
  assign waddr = ADDR_W'(slot) * ADDR_W'(CAPW) + ADDR_W'(wr_word);
  assign raddr = ADDR_W'(rd_slot) * ADDR_W'(CAPW) + ADDR_W'(rd_word);

  // Words of the codeword in flight go to the next free slot; the
  // slot is only claimed when the codeword qualifies.
  always_ff @(posedge clk) begin
    if (wr_vld && room && (32'(wr_word) < 32'(CAPW))) dmem[waddr] <= wr_data;
    if (commit && room) mmem[slot] <= {c_unc, c_syms, c_idx};
    rd_data <= dmem[raddr];
    rmeta   <= mmem[rd_slot];
  end

  always_ff @(posedge clk) begin
    if (rst || clr)          cap_count <= '0;
    else if (commit && room) cap_count <= cap_count + 1'b1;
  end

  assign {rd_unc, rd_syms, rd_idx} = rmeta;

  // R9: fill never passes the depth
  a_r9_cap_bound: assert property (@(posedge clk) disable iff (rst)
    cap_count <= CC_W'(DEPTH));
  // R9: a full store stays full until cleared
  a_r9_full_holds: assert property (@(posedge clk) disable iff (rst)
    (cap_count == CC_W'(DEPTH) && !clr) |=> (cap_count == CC_W'(DEPTH)));
  // R8: at most one entry per cycle
  a_r8_single_entry: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (cap_count == $past(cap_count) || cap_count == $past(cap_count) + 1'b1));
endmodule

// File: rtl/fec_sat_cnt.sv
module fec_sat_cnt #(
  parameter int W  = 48,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [IW-1:0] inc,
  output logic [W-1:0]  cnt
);
  logic [W:0] sum;

  assign sum = {1'b0, cnt} + (W + 1)'(inc);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= sum[W] ? '1 : sum[W-1:0];
  end

  // R10: the total never wraps downwards
  a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (cnt >= $past(cnt)));
endmodule

// File: rtl/fec_sym_capture.sv
module fec_sym_capture
  import fec_cap_pkg::*;
#(
  parameter int DW        = 40,
  parameter int SYM_BITS  = 10,
  parameter int CW_SYMS   = 544,
  parameter int UNC_LIMIT = 16,
  parameter int CAP_DEPTH = 128,
  parameter int CAP_WORDS = 4,
  parameter int CNT_W     = 48,
  parameter int CWI_W     = 16,
  parameter int LOCK_RUN  = 64,
  localparam int SC_W     = $clog2(CW_SYMS + 1),
  localparam int SLOT_W   = (CAP_DEPTH > 1) ? $clog2(CAP_DEPTH) : 1,
  localparam int WRD_W    = (CAP_WORDS > 1) ? $clog2(CAP_WORDS) : 1,
  localparam int CC_W     = $clog2(CAP_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              in_vld,
  input  logic              in_sync,
  input  logic [DW-1:0]     in_data,
  input  logic [SC_W-1:0]   thresh,
  output logic              locked,
  output logic              cw_done,
  output logic [CWI_W-1:0]  cw_idx,
  output logic [SC_W-1:0]   cw_syms,
  output logic              cw_event,
  output logic              cw_uncorr,
  output logic [CNT_W-1:0]  bit_err_total,
  output logic [CNT_W-1:0]  sym_err_total,
  output logic [CNT_W-1:0]  event_total,
  output logic [CNT_W-1:0]  uncorr_total,
  output logic [CC_W-1:0]   cap_count,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [WRD_W-1:0]  rd_word,
  output logic [DW-1:0]     rd_data,
  output logic [CWI_W-1:0]  rd_cw_idx,
  output logic [SC_W-1:0]   rd_syms,
  output logic              rd_uncorr
);
  localparam int SPB    = DW / SYM_BITS;
  localparam int BEATS  = CW_SYMS / SPB;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int BIT_W  = $clog2(DW + 1);

  logic [DW-1:0]     err;
  logic              st_vld, st_evt, st_unc, commit;
  logic [DW-1:0]     st_data;
  logic [BEAT_W-1:0] st_word;
  logic [BIT_W-1:0]  st_bits, st_syms;
  logic [CWI_W-1:0]  c_idx;
  logic [SC_W-1:0]   c_syms;
  logic [NUM_TOT-1:0][BIT_W-1:0] incs;
  logic [NUM_TOT-1:0][CNT_W-1:0] tots;

  fec_prbs_chk #(.W(DW), .LOCK_RUN(LOCK_RUN)) u_chk (
    .clk(clk), .rst(rst), .vld(in_vld), .data(in_data),
    .err(err), .locked(locked)
  );

  fec_cw_frame #(.W(DW), .SYM(SYM_BITS), .CW_SYMS(CW_SYMS),
                 .UNC_LIMIT(UNC_LIMIT), .CWI_W(CWI_W)) u_frame (
    .clk(clk), .rst(rst), .vld(in_vld), .sync(in_sync), .data(in_data),
    .err(err), .thresh(thresh), .st_vld(st_vld), .st_data(st_data),
    .st_word(st_word), .st_bits(st_bits), .st_syms(st_syms),
    .st_evt(st_evt), .st_unc(st_unc), .commit(commit), .c_idx(c_idx),
    .c_syms(c_syms), .cw_done(cw_done), .cw_idx(cw_idx),
    .cw_syms(cw_syms), .cw_event(cw_event), .cw_uncorr(cw_uncorr)
  );

  fec_cap_store #(.W(DW), .DEPTH(CAP_DEPTH), .CAPW(CAP_WORDS),
                  .BEAT_W(BEAT_W), .CWI_W(CWI_W), .SC_W(SC_W)) u_store (
    .clk(clk), .rst(rst), .clr(clr), .wr_vld(st_vld), .wr_word(st_word),
    .wr_data(st_data), .commit(commit), .c_idx(c_idx), .c_syms(c_syms),
    .c_unc(st_unc), .rd_slot(rd_slot), .rd_word(rd_word),
    .cap_count(cap_count), .rd_data(rd_data), .rd_idx(rd_cw_idx),
    .rd_syms(rd_syms), .rd_unc(rd_uncorr)
  );

  assign incs[0] = st_bits;
  assign incs[1] = st_syms;
  assign incs[2] = BIT_W'(st_evt);
  assign incs[3] = BIT_W'(st_unc);

  for (genvar k = 0; k < NUM_TOT; k++) begin : g_tot
    fec_sat_cnt #(.W(CNT_W), .IW(BIT_W)) u_cnt (
      .clk(clk), .rst(rst), .clr(clr), .inc(incs[k]), .cnt(tots[k])
    );
  end

  assign bit_err_total = tots[0];
  assign sym_err_total = tots[1];
  assign event_total   = tots[2];
  assign uncorr_total  = tots[3];
endmodule

// File: tb/fec_sym_capture_bench.sv
module fec_sym_capture_bench;
  localparam int DW = 20, SB = 10, CWS = 8, UNC = 5, DEP = 4, CAPW = 2;
  localparam int CNTW = 8, CWIW = 8, BEATS = 4;

  logic clk = 1'b0, rst = 1'b1, clr = 1'b0;
  logic in_vld = 1'b0, in_sync = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [3:0] thresh = '0;
  logic locked, cw_done, cw_event, cw_uncorr, rd_uncorr;
  logic [CWIW-1:0] cw_idx, rd_cw_idx;
  logic [3:0] cw_syms, rd_syms;
  logic [CNTW-1:0] bit_t, sym_t, evt_t, unc_t;
  logic [2:0] cap_count;
  logic [1:0] rd_slot = '0;
  logic [0:0] rd_word = '0;
  logic [DW-1:0] rd_data;

  fec_sym_capture #(.DW(DW), .SYM_BITS(SB), .CW_SYMS(CWS), .UNC_LIMIT(UNC),
    .CAP_DEPTH(DEP), .CAP_WORDS(CAPW), .CNT_W(CNTW), .CWI_W(CWIW),
    .LOCK_RUN(64)) u_fec_sym_capture (
    .clk(clk), .rst(rst), .clr(clr), .in_vld(in_vld), .in_sync(in_sync),
    .in_data(in_data), .thresh(thresh), .locked(locked), .cw_done(cw_done),
    .cw_idx(cw_idx), .cw_syms(cw_syms), .cw_event(cw_event),
    .cw_uncorr(cw_uncorr), .bit_err_total(bit_t), .sym_err_total(sym_t),
    .event_total(evt_t), .uncorr_total(unc_t), .cap_count(cap_count),
    .rd_slot(rd_slot), .rd_word(rd_word), .rd_data(rd_data),
    .rd_cw_idx(rd_cw_idx), .rd_syms(rd_syms), .rd_uncorr(rd_uncorr)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [30:0] g = 31'h1;
  logic [DW-1:0] log_q [9][2];

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic gen_beat(output logic [DW-1:0] d);
    for (int i = DW - 1; i >= 0; i--) begin
      d[i] = g[30] ^ g[27];
      g = {g[29:0], d[i]};
    end
  endtask

  // Symbol s of a codeword: word s/2, slot s%2; one flipped bit, two when s is even.
  function automatic logic [DW-1:0] cw_mask(input int k, input int beat);
    logic [DW-1:0] m = '0;
    for (int sl = 0; sl < 2; sl++) begin
      int s = beat * 2 + sl;
      if (s < k) begin
        m[SB * sl + s] = 1'b1;
        if (s % 2 == 0) m[SB * sl + s + 1] = 1'b1;
      end
    end
    return m;
  endfunction

  function automatic int cw_bits(input int k);
    int n = 0;
    for (int s = 0; s < k; s++) n += (s % 2 == 0) ? 2 : 1;
    return n;
  endfunction

  task automatic drive(input logic [DW-1:0] d, input logic s);
    @(negedge clk);
    in_vld = 1'b1; in_data = d; in_sync = s;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_vld = 1'b0; in_sync = 1'b0;
    end
  endtask

  task automatic clean(input int n);
    logic [DW-1:0] d;
    for (int i = 0; i < n; i++) begin gen_beat(d); drive(d, 1'b0); end
    idle(3);
  endtask

  task automatic do_clr();
    @(negedge clk); clr = 1'b1; in_vld = 1'b0;
    @(negedge clk); clr = 1'b0;
    idle(2);
  endtask

  task automatic sweep(input int thr);
    logic [DW-1:0] d;
    thresh = 4'(thr);
    for (int k = 0; k <= 8; k++)
      for (int b = 0; b < BEATS; b++) begin
        gen_beat(d);
        d = d ^ cw_mask(k, b);
        if (b < CAPW) log_q[k][b] = d;
        drive(d, (k == 0 && b == 0));
      end
    idle(4);
  endtask

  task automatic rd_entry(input int slot, input int k, input int unc, input string tag);
    for (int w = 0; w < CAPW; w++) begin
      @(negedge clk); rd_slot = 2'(slot); rd_word = 1'(w);
      @(negedge clk);
      chk({tag, " data"}, rd_data, log_q[k][w]);
    end
    chk({tag, " index"}, rd_cw_idx, k);
    chk({tag, " count"}, rd_syms, k);
    chk({tag, " uncorr"}, rd_uncorr, unc);
  endtask

  initial begin
    int exp_bits;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);
    // R13 reset state
    chk("R13 locked", locked, 0);
    chk("R13 bits", bit_t, 0);
    chk("R13 events", evt_t, 0);
    chk("R13 cap", cap_count, 0);

    // R2 lock boundary: 80 bits leave 49 matched predictions, 100 bits give 69
    clean(4);
    chk("R2 no lock after 4 words", locked, 0);
    clean(1);
    chk("R2 lock after 5 words", locked, 1);

    // Sweep 1: threshold 3, codeword k has k errored symbols
    sweep(3);
    exp_bits = 0;
    for (int k = 0; k <= 8; k++) exp_bits += cw_bits(k);
    chk("R1 bit total", bit_t, exp_bits);
    chk("R4 symbol total", sym_t, 36);
    chk("R6 events above 3 (k=3 ignored)", evt_t, 5);
    chk("R7 uncorrectable above 5", unc_t, 3);
    chk("R9 store full at depth", cap_count, DEP);
    for (int e = 0; e < DEP; e++)
      rd_entry(e, e + 4, (e + 4 > UNC) ? 1 : 0, "R8 R12 R5 sweep1 entry");

    // R11 clear
    do_clr();
    chk("R11 bits cleared", bit_t, 0);
    chk("R11 symbols cleared", sym_t, 0);
    chk("R11 events cleared", evt_t, 0);
    chk("R11 uncorr cleared", unc_t, 0);
    chk("R11 cap cleared", cap_count, 0);

    // Sweep 2: threshold 6; k=6 is stored as uncorrectable only
    sweep(6);
    chk("R6 events above 6", evt_t, 2);
    chk("R7 uncorrectable", unc_t, 3);
    chk("R8 three entries", cap_count, 3);
    for (int e = 0; e < 3; e++)
      rd_entry(e, e + 6, 1, "R8 sweep2 entry");

    // R3 loss of lock on a fully inverted word
    do_clr();
    begin
      logic [DW-1:0] d;
      gen_beat(d);
      drive(d ^ '1, 1'b0);
    end
    idle(3);
    chk("R3 errors of losing word", bit_t, 20);
    chk("R3 lock dropped", locked, 0);
    for (int i = 0; i < 3; i++) drive(20'hAAAAA, 1'b0);
    idle(3);
    chk("R2 hunting errors ignored", bit_t, 20);
    clean(8);
    chk("R3 relock", locked, 1);
    chk("R3 clean after relock", bit_t, 20);

    // R10 saturation and R9 counting past a full store
    do_clr();
    thresh = 4'd7;
    for (int c = 0; c < 10; c++)
      for (int b = 0; b < BEATS; b++) begin
        logic [DW-1:0] d;
        gen_beat(d);
        drive(d ^ 20'h0F00F, (c == 0 && b == 0));
      end
    idle(4);
    chk("R10 bit total saturates", bit_t, 255);
    chk("R4 symbol total", sym_t, 80);
    chk("R9 events counted beyond store", evt_t, 10);
    chk("R7 uncorrectable count", unc_t, 10);
    chk("R9 store holds at depth", cap_count, DEP);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R13 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule